// File: doc/BRIEF.md
# Single-Cycle RV32 Subset Processor Core

This block is a 32-bit processor that retires one instruction on every rising clock edge. It uses two separate storage arrays with independent ports: one for instruction words and one for data words. It runs a small part of the RV32 base set:

- register-register arithmetic and logic, with an integer multiply
- immediate arithmetic, logic and left shift
- word stores
- two conditional branches: equal, and signed less-than
- a dedicated all-zeros halt word that freezes the core

The surrounding logic fills the instruction array through a write port while reset is held. It then releases reset and lets the core run until the `halted` flag rises. After that it reads results back out of the data array through a combinational peek port. Every result a program produces reaches the outside only through stores, because there are no loads.

Top module: `rvl_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and nothing is written to the register file or the data array. This holds even though the instruction at address 0 is being decoded during reset.
- R2: Instructions are fetched from the word at index PC[31:2]. Any instruction that is not a branch and not the halt word advances the PC by 4.
- R3: Opcode 0110011 performs an operation on rd = rs1 op rs2, selected by funct7/funct3:
  - add: 0000000/000
  - sub: 0100000/000
  - mul (low 32 bits): 0000001/000
  - sll by rs2[4:0]: 0000000/001
  - signed slt: 0000000/010
  - xor: 0000000/100
  - or: 0000000/110
  - and: 0000000/111
- R4: Opcode 0010011 performs an operation on rs1 and the sign-extended 12-bit immediate in bits [31:20], selected by funct3:
  - addi: 000
  - slli with shamt in [24:20] and funct7 zero: 001
  - slti: 010
  - xori: 100
  - ori: 110
  - andi: 111
- R5: Opcode 0100011 with funct3 010 writes rs2 to data word index (rs1 + imm)[..:2] on the rising edge. The immediate is sign-extended from {bits[31:25], bits[11:7]}. The peek port reads the data array combinationally.
- R6: Opcode 1100011 with funct3 000 loads PC + B-immediate when rs1 == rs2, and PC + 4 otherwise. The B-immediate is 13 bits, sign-extended, and its bit 0 is zero. Both forward and backward targets work.
- R7: Opcode 1100011 with funct3 100 takes the branch when rs1 < rs2 compared as signed values.
- R8: Register x0 reads as zero. A write that names x0 as its destination is dropped.
- R9: The all-zeros word raises `halted`. The PC then holds its value, and no register or data write happens while it is fetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| progWe | input | 1 | Write strobe for the instruction array |
| progAddr | input | $clog2(IMEM_WORDS) | Word index for instruction writes |
| progWord | input | 32 | Instruction word to store |
| peekAddr | input | $clog2(DMEM_WORDS) | Word index for reading the data array |
| peekWord | output | 32 | Data word at `peekAddr`, combinational |
| pcOut | output | 32 | Current program counter |
| halted | output | 1 | High while the fetched word is the halt word |

## Verification
The bench targets several specific failure modes, each chosen so that a wrong design leaves a visible mark:

- **Signed compares.** Operands of opposite sign feed both the slt forms and the less-than branch. An unsigned compare would store the wrong flag, or would skip a block that should run.
- **Immediate handling.** Negative immediates are used, along with a shift by 31. A missing sign extension or a truncated shift amount shows up directly in the stored results.
- **Backward branch loop.** A loop that branches backward counts to a known value. A broken B-immediate assembly would either loop forever or exit early.
- **Halt word.** Stores are placed after the halt word. A core that runs past the halt word overwrites a known location.
- **Reset.** A store sits at address 0 while reset is held. A core that does not gate writes during reset would clobber data before it starts running.

// File: rtl/rvl_pkg.sv
package rvl_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_SLT, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL
  } alu_op_e;

  typedef enum logic [1:0] {IMM_I, IMM_S, IMM_B, IMM_J} imm_sel_e;

  typedef struct packed {
    logic     regWrite;
    logic     memWrite;
    logic     aluSrcImm;
    logic     branch;
    logic     branchLt;
    logic     halt;
    imm_sel_e immSel;
    alu_op_e  aluOp;
  } ctrl_t;
endpackage

// File: rtl/rvl_imem.sv
module rvl_imem #(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             wIdx,
  input  logic [rvl_pkg::XLEN-1:0]  wData,
  input  logic [AW-1:0]             rIdx,
  output logic [rvl_pkg::XLEN-1:0]  rData
);
  logic [rvl_pkg::XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wIdx] <= wData;
  end

  assign rData = mem[rIdx];
endmodule

// File: rtl/rvl_dmem.sv
module rvl_dmem #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             wIdx,
  input  logic [rvl_pkg::XLEN-1:0]  wData,
  input  logic [AW-1:0]             rIdx,
  output logic [rvl_pkg::XLEN-1:0]  rData
);
  logic [rvl_pkg::XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wIdx] <= wData;
  end

  assign rData = mem[rIdx];

  // R5: a store lands at its index with the register data
  assert_store_lands_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wIdx)] == $past(wData));
endmodule

// File: rtl/rvl_control.sv
module rvl_control
  import rvl_pkg::*;
(
  input  logic       rst,
  input  logic       instrZero,
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctrl_t      ctrl
);
  logic    opLegal;
  alu_op_e opByF3;

  always_comb begin
    opLegal = 1'b1;
    opByF3  = ALU_ADD;
    unique case (funct3)
      3'b000: opByF3 = ALU_ADD;
      3'b001: opByF3 = ALU_SLL;
      3'b010: opByF3 = ALU_SLT;
      3'b100: opByF3 = ALU_XOR;
      3'b110: opByF3 = ALU_OR;
      3'b111: opByF3 = ALU_AND;
      default: opLegal = 1'b0;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.aluOp  = ALU_ADD;
    ctrl.immSel = IMM_I;
    if (instrZero) begin
      ctrl.halt = 1'b1;
    end else begin
      unique case (opcode)
        OPC_REG: begin
          if (funct7 == 7'b0000001 && funct3 == 3'b000) begin
            ctrl.aluOp = ALU_MUL;
            ctrl.regWrite = 1'b1;
          end else if (funct7 == 7'b0100000 && funct3 == 3'b000) begin
            ctrl.aluOp = ALU_SUB;
            ctrl.regWrite = 1'b1;
          end else if (funct7 == 7'b0000000 && opLegal) begin
            ctrl.aluOp = opByF3;
            ctrl.regWrite = 1'b1;
          end
        end
        OPC_IMM: begin
          if (opLegal && (funct3 != 3'b001 || funct7 == 7'b0000000)) begin
            ctrl.aluOp     = opByF3;
            ctrl.aluSrcImm = 1'b1;
            ctrl.regWrite  = 1'b1;
          end
        end
        OPC_STORE: begin
          if (funct3 == 3'b010) begin
            ctrl.aluSrcImm = 1'b1;
            ctrl.immSel    = IMM_S;
            ctrl.memWrite  = 1'b1;
          end
        end
        OPC_BR: begin
          if (funct3 == 3'b000 || funct3 == 3'b100) begin
            ctrl.branch   = 1'b1;
            ctrl.branchLt = funct3[2];
            ctrl.aluOp    = ALU_SUB;
            ctrl.immSel   = IMM_B;
          end
        end
        default: ;
      endcase
    end
    if (rst) begin
      ctrl.regWrite = 1'b0;
      ctrl.memWrite = 1'b0;
    end
  end
endmodule

// File: rtl/rvl_datapath.sv
module rvl_datapath
  import rvl_pkg::*;
#(
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:7]        instrHi,
  input  ctrl_t              ctrl,
  output logic [XLEN-1:0]    pc,
  output logic [DMEM_AW-1:0] storeIdx,
  output logic [XLEN-1:0]    storeData
);
  localparam int REGS = 32;
  localparam int RIW  = $clog2(REGS);

  logic [24:0]     f;
  logic [RIW-1:0]  rs1Idx, rs2Idx, rdIdx;
  logic [XLEN-1:0] regs [REGS];
  logic [XLEN-1:0] rd1, rd2, immExt, srcB, aluResult;
  logic [XLEN-1:0] pcPlus4, branchTarget;
  logic            isEqual, isLessS, takeBranch;

  // f[k] holds instruction bit k+7
  assign f      = instrHi;
  assign rs1Idx = f[12:8];
  assign rs2Idx = f[17:13];
  assign rdIdx  = f[4:0];

  always_comb begin
    unique case (ctrl.immSel)
      IMM_I: immExt = {{20{f[24]}}, f[24:13]};
      IMM_S: immExt = {{20{f[24]}}, f[24:18], f[4:0]};
      IMM_B: immExt = {{19{f[24]}}, f[24], f[0], f[23:18], f[4:1], 1'b0};
      IMM_J: immExt = {{11{f[24]}}, f[24], f[12:5], f[13], f[23:14], 1'b0};
    endcase
  end

  assign rd1  = regs[rs1Idx];
  assign rd2  = regs[rs2Idx];
  assign srcB = ctrl.aluSrcImm ? immExt : rd2;

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD: aluResult = rd1 + srcB;
      ALU_SUB: aluResult = rd1 - srcB;
      ALU_MUL: aluResult = rd1 * srcB;
      ALU_SLT: aluResult = {{(XLEN-1){1'b0}}, $signed(rd1) < $signed(srcB)};
      ALU_AND: aluResult = rd1 & srcB;
      ALU_OR:  aluResult = rd1 | srcB;
      ALU_XOR: aluResult = rd1 ^ srcB;
      ALU_SLL: aluResult = rd1 << srcB[4:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < REGS; k++) regs[k] <= '0;
    end else if (ctrl.regWrite && rdIdx != '0) begin
      regs[rdIdx] <= aluResult;
    end
  end

  assign isEqual      = (aluResult == '0);
  assign isLessS      = $signed(rd1) < $signed(rd2);
  assign takeBranch   = ctrl.branch & (ctrl.branchLt ? isLessS : isEqual);
  assign pcPlus4      = pc + 32'd4;
  assign branchTarget = pc + immExt;

  always_ff @(posedge clk) begin
    if (rst)             pc <= '0;
    else if (!ctrl.halt) pc <= takeBranch ? branchTarget : pcPlus4;
  end

  assign storeIdx  = aluResult[DMEM_AW+1:2];
  assign storeData = rd2;

  assert_pc_reset_R1: assert property (@(posedge clk)
    rst |=> pc == '0);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.halt && !ctrl.branch) |=> pc == $past(pc) + 32'd4);

  assert_beq_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && !ctrl.branchLt && rd1 == rd2) |=> pc == $past(pc) + $past(immExt));

  assert_blt_signed_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && ctrl.branchLt && $signed(rd1) < $signed(rd2))
      |=> pc == $past(pc) + $past(immExt));

  assert_x0_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rs1Idx == '0) |-> rd1 == '0);

  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.halt |=> pc == $past(pc));
endmodule

// File: rtl/rvl_core.sv
module rvl_core
  import rvl_pkg::*;
#(
  parameter int IMEM_WORDS = 128,
  parameter int DMEM_WORDS = 64,
  localparam int IMEM_AW = $clog2(IMEM_WORDS),
  localparam int DMEM_AW = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               progWe,
  input  logic [IMEM_AW-1:0] progAddr,
  input  logic [XLEN-1:0]    progWord,
  input  logic [DMEM_AW-1:0] peekAddr,
  output logic [XLEN-1:0]    peekWord,
  output logic [XLEN-1:0]    pcOut,
  output logic               halted
);
  logic [XLEN-1:0]    instr;
  logic               instrZero;
  ctrl_t              ctrl;
  logic [DMEM_AW-1:0] storeIdx;
  logic [XLEN-1:0]    storeData;

  rvl_imem #(.WORDS(IMEM_WORDS)) u_imem (
    .clk(clk), .we(progWe), .wIdx(progAddr), .wData(progWord),
    .rIdx(pcOut[IMEM_AW+1:2]), .rData(instr)
  );

  assign instrZero = (instr == '0);

  rvl_control u_control (
    .rst(rst), .instrZero(instrZero), .opcode(instr[6:0]),
    .funct3(instr[14:12]), .funct7(instr[31:25]), .ctrl(ctrl)
  );

  rvl_datapath #(.DMEM_AW(DMEM_AW)) u_datapath (
    .clk(clk), .rst(rst), .instrHi(instr[31:7]), .ctrl(ctrl),
    .pc(pcOut), .storeIdx(storeIdx), .storeData(storeData)
  );

  rvl_dmem #(.WORDS(DMEM_WORDS)) u_dmem (
    .clk(clk), .rst(rst), .we(ctrl.memWrite), .wIdx(storeIdx),
    .wData(storeData), .rIdx(peekAddr), .rData(peekWord)
  );

  assign halted = ctrl.halt;
endmodule

// File: tb/rvl_core_bench.sv
module rvl_core_bench;
  localparam int IMEM_WORDS = 128;
  localparam int DMEM_WORDS = 64;
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int NVEC = 16;

  typedef struct packed {
    logic        isImm;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [11:0] a;
    logic [11:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 3'b000, 7'h00, 12'd100,  12'd23,   32'h0000007B}, // R3 add
    '{1'b0, 3'b000, 7'h20, 12'd5,    12'd9,    32'hFFFFFFFC}, // R3 sub
    '{1'b0, 3'b000, 7'h01, 12'hFF9,  12'd6,    32'hFFFFFFD6}, // R3 mul
    '{1'b0, 3'b111, 7'h00, 12'h0F0,  12'h03C,  32'h00000030}, // R3 and
    '{1'b0, 3'b110, 7'h00, 12'h0F0,  12'h03C,  32'h000000FC}, // R3 or
    '{1'b0, 3'b100, 7'h00, 12'h0F0,  12'h03C,  32'h000000CC}, // R3 xor
    '{1'b0, 3'b010, 7'h00, 12'hFFD,  12'd2,    32'h00000001}, // R3 slt signed
    '{1'b0, 3'b001, 7'h00, 12'd3,    12'd4,    32'h00000030}, // R3 sll
    '{1'b1, 3'b000, 7'h00, 12'd100,  12'hED4,  32'hFFFFFF38}, // R4 addi neg
    '{1'b1, 3'b010, 7'h00, 12'd5,    12'hFFF,  32'h00000000}, // R4 slti
    '{1'b1, 3'b100, 7'h00, 12'h0F0,  12'hFFF,  32'hFFFFFF0F}, // R4 xori
    '{1'b1, 3'b001, 7'h00, 12'd1,    12'd31,   32'h80000000}, // R4 slli 31
    '{1'b1, 3'b111, 7'h00, 12'hFFF,  12'h7FF,  32'h000007FF}, // R4 andi
    '{1'b1, 3'b110, 7'h00, 12'h100,  12'h00F,  32'h0000010F}, // R4 ori
    '{1'b0, 3'b010, 7'h00, 12'd2,    12'hFFD,  32'h00000000}, // R3 slt
    '{1'b0, 3'b000, 7'h01, 12'h7D0,  12'h830,  32'hFFC2F700}  // R3 mul big
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           progWe = 1'b0;
  logic [IAW-1:0] progAddr = '0;
  logic [31:0]    progWord = '0;
  logic [DAW-1:0] peekAddr = '0;
  logic [31:0]    peekWord, pcOut;
  logic           halted;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] prog [IMEM_WORDS];
  int progLen = 0;

  always #4 clk = ~clk;

  rvl_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_rvl_core (
    .clk(clk), .rst(rst), .progWe(progWe), .progAddr(progAddr),
    .progWord(progWord), .peekAddr(peekAddr), .peekWord(peekWord),
    .pcOut(pcOut), .halted(halted)
  );

  function automatic logic [31:0] encR(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] encI(logic [11:0] imm, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd);
    return {imm, rs1, f3, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] encS(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] encB(logic [12:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic emit(logic [31:0] w);
    prog[progLen] = w;
    progLen++;
  endtask

  task automatic loadProg();
    rst = 1'b1;
    for (int i = 0; i < progLen; i++) begin
      @(negedge clk);
      progWe = 1'b1; progAddr = IAW'(i); progWord = prog[i];
    end
    @(negedge clk);
    progWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic runToHalt(int limit);
    rst = 1'b0;
    for (int n = 0; n < limit && !halted; n++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic peek(int idx, output logic [31:0] val);
    peekAddr = DAW'(idx);
    #1;
    val = peekWord;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pcHalt;
    repeat (3) @(negedge clk);
    check("R1 pc after reset", pcOut, 32'h0);

    // Program 1: ALU vector table
    progLen = 0;
    for (int i = 0; i < NVEC; i++) begin
      emit(encI(VECS[i].a, 5'd0, 3'b000, 5'd1));
      emit(encI(VECS[i].b, 5'd0, 3'b000, 5'd2));
      if (VECS[i].isImm) emit(encI(VECS[i].b, 5'd1, VECS[i].f3, 5'd3));
      else               emit(encR(VECS[i].f7, 5'd2, 5'd1, VECS[i].f3, 5'd3));
      emit(encS(12'(4 * i), 5'd3, 5'd0));
    end
    emit(encI(12'd9, 5'd0, 3'b000, 5'd4));   // x4 = 9
    emit(encS(12'd64, 5'd4, 5'd0));          // mem[16] = 9
    emit(encI(12'd55, 5'd0, 3'b000, 5'd0));  // write x0 (dropped)
    emit(encS(12'd64, 5'd0, 5'd0));          // mem[16] = x0
    emit(32'h0);
    loadProg();
    runToHalt(500);
    check("R9 halted after program 1", {31'b0, halted}, 32'h1);
    check("R2 pc at halt word", pcOut, 32'd272);
    for (int i = 0; i < NVEC; i++) begin
      peek(i, v);
      check(VECS[i].isImm ? "R4 immediate op result" : "R3 register op result", v, VECS[i].exp);
    end
    peek(16, v);
    check("R8 x0 stays zero", v, 32'h0);

    // Program 2: branches, loop and halt
    progLen = 0;
    emit(encI(12'd5, 5'd0, 3'b000, 5'd1));           // 0 x1=5
    emit(encI(12'hFFD, 5'd0, 3'b000, 5'd2));         // 1 x2=-3
    emit(encB(13'd8, 5'd2, 5'd1, 3'b000));           // 2 beq not taken
    emit(encI(12'd11, 5'd0, 3'b000, 5'd5));          // 3 x5=11
    emit(encB(13'd8, 5'd1, 5'd2, 3'b100));           // 4 blt -3<5 taken
    emit(encI(12'd99, 5'd0, 3'b000, 5'd5));          // 5 skipped
    emit(encB(13'd8, 5'd2, 5'd1, 3'b100));           // 6 blt 5<-3 not taken
    emit(encI(12'd22, 5'd0, 3'b000, 5'd6));          // 7 x6=22
    emit(encB(13'd8, 5'd1, 5'd1, 3'b000));           // 8 beq taken
    emit(encI(12'd77, 5'd0, 3'b000, 5'd6));          // 9 skipped
    emit(encS(12'd0, 5'd5, 5'd0));                   // 10 mem[0]=x5
    emit(encS(12'd4, 5'd6, 5'd0));                   // 11 mem[1]=x6
    emit(encI(12'd0, 5'd0, 3'b000, 5'd7));           // 12 x7=0
    emit(encI(12'd3, 5'd0, 3'b000, 5'd8));           // 13 x8=3
    emit(encI(12'd1, 5'd7, 3'b000, 5'd7));           // 14 x7++
    emit(encB(13'h1FFC, 5'd8, 5'd7, 3'b100));       // 15 blt back to 14
    emit(encS(12'd8, 5'd7, 5'd0));                   // 16 mem[2]=x7
    emit(32'h0);                                     // 17 halt
    emit(encI(12'd1, 5'd0, 3'b000, 5'd9));           // 18 must not run
    emit(encS(12'd12, 5'd9, 5'd0));                  // 19 must not run
    loadProg();
    runToHalt(200);
    pcHalt = pcOut;
    check("R9 pc at halt word", pcHalt, 32'd68);
    peek(0, v); check("R6 beq not taken falls through", v, 32'd11);
    peek(1, v); check("R7 blt signed not taken, R6 beq taken", v, 32'd22);
    peek(2, v); check("R7 backward blt loop count", v, 32'd3);
    repeat (5) @(negedge clk);
    check("R9 pc holds", pcOut, pcHalt);
    check("R9 halted stays", {31'b0, halted}, 32'h1);
    peek(3, v); check("R9 no store after halt", v, 32'h30);

    // Program 3: store at address 0 held in reset
    progLen = 0;
    emit(encS(12'd0, 5'd0, 5'd0));                   // mem[0] = 0
    emit(32'h0);
    loadProg();
    repeat (3) @(negedge clk);
    check("R1 pc held at zero in reset", pcOut, 32'h0);
    peek(0, v); check("R1 no store during reset", v, 32'd11);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    peek(0, v); check("R5 store after reset release", v, 32'h0);
    check("R2 pc advanced by 4", pcOut, 32'd4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule